// File: doc/BRIEF.md
# Refresh and Low-Power Mode Sequencer

This block is the controller-side sequencer that keeps an SDRAM refreshed and moves it into and out of its two low-power states. It runs its own interval timer and owes the memory one AUTO REFRESH per interval. The host may defer these refreshes up to a set limit, and the owed ones are then issued back to back. The block drives the clock-enable pin and the four active-low command pins (chip select, row strobe, column strobe, write enable). AUTO REFRESH, self-refresh entry and deep power-down entry all come out of one state machine. They differ only in the pin pattern and the clock-enable level.

The host holds a level request to stay in self refresh or deep power-down. Entry waits until no refresh is owed and all banks are idle. Self-refresh entry is also refused while the over-temperature input is high. Exit begins when the request drops and the clock-stable flag is high. After self refresh the block pads with NOP commands for the exit time. After deep power-down the memory contents are lost, so the status output stays at "reinitialise" until the host acknowledges.

Top module: `lpm_refresh_seq`

## Requirements
- R1: While reset is held and right after it, CKE is high, the pins carry NOP (CS#=0, RAS#=1, CAS#=1, WE#=1), mode is 0 (active) and ref_busy is low.
- R2: One refresh becomes owed every REFI_CYC cycles. With banks idle and no deferral, it is issued as AUTO REFRESH: CS#=0, RAS#=0, CAS#=0, WE#=1 with CKE high.
- R3: While defer_ref is high, owed refreshes are held back, up to MAX_OWED of them. When MAX_OWED are owed, one is issued even while deferral is requested. After deferral ends, all owed refreshes are issued back to back.
- R4: No AUTO REFRESH is issued unless banks_idle was high in the cycle before the command.
- R5: After an AUTO REFRESH, CKE stays high and no other command is issued for RFC_CYC cycles counted from the command. Mode reads 1 (refreshing) during this time.
- R6: ref_busy is high whenever at least one refresh is owed or a refresh period is running, and low otherwise.
- R7: Self-refresh entry is the AUTO REFRESH pin pattern with CKE low. It is issued only when sr_req is high, banks are idle and no refresh is owed. Mode then reads 2 (self refresh).
- R8: While overtemp is high, a self-refresh request is refused and the block stays active.
- R9: Self refresh is left only after sr_req is low and clk_stable is high. CKE then goes high, and exactly XSR_CYC cycles of NOP follow with mode 3 (exiting) before the block is active again.
- R10: Deep power-down entry is CS#=0, RAS#=1, CAS#=1, WE#=0 with CKE low. It is issued only with banks idle and no refresh owed, and it takes priority over a simultaneous self-refresh request. Mode then reads 4 (deep power-down).
- R11: Deep power-down is left when dpd_req is low and clk_stable is high. CKE goes high and mode reads 5 (reinitialise) until reinit_ack is seen. Mode then returns to 0.
- R12: In self refresh and deep power-down, CKE stays low and no refresh command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| dpd_req | input | 1 | Level request to enter and stay in deep power-down |
| overtemp | input | 1 | Case temperature above the self-refresh limit |
| banks_idle | input | 1 | All banks are precharged |
| clk_stable | input | 1 | Memory clock is stable |
| defer_ref | input | 1 | Host asks to postpone owed refreshes |
| reinit_ack | input | 1 | Host has reinitialised the memory after deep power-down |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ref_busy | output | 1 | A refresh is owed or in progress |
| mode | output | 3 | 0 active, 1 refreshing, 2 self refresh, 3 exiting, 4 deep power-down, 5 reinitialise |

## Verification
A vector table drives every combination of self-refresh request, deep power-down request, over-temperature and bank idleness from a clean start. The resulting mode and CKE separate a granted entry from a refused one and show which low-power request wins. Directed runs with deferral held, released and held past the limit tell normal, postponed and forced refreshes apart, and a run with busy banks shows refresh waiting on idleness. Exits are tried with the clock-stable flag held low, to show that CKE waits for it, and then high, to measure the NOP padding and the hold on the reinitialise status.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [3:0] {
    S_ACTIVE,
    S_REF_CMD,
    S_RFC_WAIT,
    S_SRE_CMD,
    S_SELF,
    S_XSR,
    S_DPDE_CMD,
    S_DEEP,
    S_REINIT
  } lpm_state_e;

  localparam logic [2:0] MODE_ACTIVE  = 3'd0;
  localparam logic [2:0] MODE_REFRESH = 3'd1;
  localparam logic [2:0] MODE_SELF    = 3'd2;
  localparam logic [2:0] MODE_EXITING = 3'd3;
  localparam logic [2:0] MODE_DEEP    = 3'd4;
  localparam logic [2:0] MODE_REINIT  = 3'd5;

  // command codes as {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CODE_NOP = 4'b0111;
  localparam logic [3:0] CODE_REF = 4'b0001;
  localparam logic [3:0] CODE_DPD = 4'b0110;

  typedef struct packed {
    logic       cke;
    logic [3:0] code;
  } pin_set_t;

  function automatic pin_set_t pins_for(lpm_state_e s);
    pin_set_t p;
    case (s)
      S_REF_CMD:  p = '{cke: 1'b1, code: CODE_REF};
      S_SRE_CMD:  p = '{cke: 1'b0, code: CODE_REF};
      S_SELF:     p = '{cke: 1'b0, code: CODE_NOP};
      S_DPDE_CMD: p = '{cke: 1'b0, code: CODE_DPD};
      S_DEEP:     p = '{cke: 1'b0, code: CODE_NOP};
      default:    p = '{cke: 1'b1, code: CODE_NOP};
    endcase
    return p;
  endfunction

  function automatic logic [2:0] mode_for(lpm_state_e s);
    case (s)
      S_REF_CMD, S_RFC_WAIT: return MODE_REFRESH;
      S_SRE_CMD, S_SELF:     return MODE_SELF;
      S_XSR:                 return MODE_EXITING;
      S_DPDE_CMD, S_DEEP:    return MODE_DEEP;
      S_REINIT:              return MODE_REINIT;
      default:               return MODE_ACTIVE;
    endcase
  endfunction

  // interval timer runs only while the memory depends on external refresh
  function automatic logic tracker_runs(lpm_state_e s);
    return (s == S_ACTIVE) || (s == S_REF_CMD) || (s == S_RFC_WAIT) || (s == S_XSR);
  endfunction

endpackage

// File: rtl/lpm_refi_tracker.sv
module lpm_refi_tracker #(
  parameter int REFI_CYC = 780,
  parameter int MAX_OWED = 8,
  localparam int CW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          consume,
  output logic [OW-1:0] owed,
  output logic          owed_full
);

  logic [CW-1:0] cnt_q;
  logic          tick;

  function automatic logic [OW-1:0] owed_next(logic [OW-1:0] cur, logic add, logic sub);
    if (add && !sub && cur != OW'(MAX_OWED)) return cur + 1'b1;
    if (sub && !add && cur != '0)            return cur - 1'b1;
    return cur;
  endfunction

  assign tick      = run && (cnt_q == CW'(REFI_CYC - 1));
  assign owed_full = (owed == OW'(MAX_OWED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      owed  <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      owed  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      owed  <= owed_next(owed, tick, consume);
    end
  end

endmodule

// File: rtl/lpm_span_timer.sv
module lpm_span_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (!done)   cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/lpm_pin_drive.sv
module lpm_pin_drive
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  output logic       cke,
  output logic       cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic [2:0] mode
);

  pin_set_t pins;

  always_comb begin
    pins = pins_for(state);
    cke  = pins.cke;
    {cs_n, ras_n, cas_n, we_n} = pins.code;
    mode = mode_for(state);
  end

endmodule

// File: rtl/lpm_refresh_seq.sv
module lpm_refresh_seq #(
  parameter int REFI_CYC = 780,
  parameter int RFC_CYC  = 10,
  parameter int XSR_CYC  = 14,
  parameter int MAX_OWED = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       dpd_req,
  input  logic       overtemp,
  input  logic       banks_idle,
  input  logic       clk_stable,
  input  logic       defer_ref,
  input  logic       reinit_ack,
  output logic       cke,
  output logic       cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic       ref_busy,
  output logic [2:0] mode
);
  import lpm_pkg::*;

  localparam int SPAN_MAX = (RFC_CYC > XSR_CYC) ? RFC_CYC : XSR_CYC;
  localparam int TW       = $clog2(SPAN_MAX + 1);
  localparam int OW       = $clog2(MAX_OWED + 1);

  lpm_state_e    state_q, state_d;
  logic [OW-1:0] owed;
  logic          owed_full;
  logic          span_done;
  logic          span_load;
  logic [TW-1:0] span_val;

  // named internal events
  logic ev_ref_issue;
  logic ev_ref_wanted;
  logic ev_lp_gate;
  logic ev_sr_exit;
  logic ev_dpd_exit;

  assign ev_ref_issue  = (state_q == S_REF_CMD);
  assign ev_ref_wanted = (owed != '0) && banks_idle && (!defer_ref || owed_full);
  assign ev_lp_gate    = (owed == '0) && banks_idle;
  assign ev_sr_exit    = !sr_req && clk_stable;
  assign ev_dpd_exit   = !dpd_req && clk_stable;

  lpm_refi_tracker #(
    .REFI_CYC (REFI_CYC),
    .MAX_OWED (MAX_OWED)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tracker_runs(state_q)),
    .consume   (ev_ref_issue),
    .owed      (owed),
    .owed_full (owed_full)
  );

  lpm_span_timer #(.W(TW)) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (span_load),
    .load_val (span_val),
    .done     (span_done)
  );

  always_comb begin
    state_d   = state_q;
    span_load = 1'b0;
    span_val  = '0;
    case (state_q)
      S_ACTIVE: begin
        if (ev_ref_wanted)                         state_d = S_REF_CMD;
        else if (ev_lp_gate && dpd_req)            state_d = S_DPDE_CMD;
        else if (ev_lp_gate && sr_req && !overtemp) state_d = S_SRE_CMD;
      end
      S_REF_CMD: begin
        span_load = 1'b1;
        span_val  = TW'(RFC_CYC - 2);
        state_d   = S_RFC_WAIT;
      end
      S_RFC_WAIT: if (span_done) state_d = S_ACTIVE;
      S_SRE_CMD:  state_d = S_SELF;
      S_SELF: begin
        if (ev_sr_exit) begin
          span_load = 1'b1;
          span_val  = TW'(XSR_CYC - 1);
          state_d   = S_XSR;
        end
      end
      S_XSR:      if (span_done) state_d = S_ACTIVE;
      S_DPDE_CMD: state_d = S_DEEP;
      S_DEEP:     if (ev_dpd_exit) state_d = S_REINIT;
      S_REINIT:   if (reinit_ack) state_d = S_ACTIVE;
      default:    state_d = S_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_ACTIVE;
    else        state_q <= state_d;
  end

  lpm_pin_drive u_pins (
    .state (state_q),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .mode  (mode)
  );

  assign ref_busy = (owed != '0) || (state_q == S_REF_CMD) || (state_q == S_RFC_WAIT);

endmodule

// File: rtl/lpm_refresh_seq_chk.sv
module lpm_refresh_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sr_req,
  input logic       dpd_req,
  input logic       overtemp,
  input logic       banks_idle,
  input logic       reinit_ack,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [2:0] mode
);

  logic [3:0] code;
  assign code = {cs_n, ras_n, cas_n, we_n};

  AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && code == 4'b0001) |-> $past(banks_idle)); // R4

  AST_RFC_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> cke); // R5

  AST_SR_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && code == 4'b0001) |-> ($past(banks_idle) && $past(sr_req) && !$past(overtemp))); // R8

  AST_XSR_NOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (cke && code == 4'b0111)); // R9

  AST_DPD_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && code == 4'b0110) |-> ($past(banks_idle) && $past(dpd_req))); // R10

  AST_REINIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !reinit_ack) |=> (mode == 3'd5)); // R11

  AST_LOWPWR_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 || mode == 3'd4) |-> !cke); // R12

endmodule

bind lpm_refresh_seq lpm_refresh_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sr_req     (sr_req),
  .dpd_req    (dpd_req),
  .overtemp   (overtemp),
  .banks_idle (banks_idle),
  .reinit_ack (reinit_ack),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .mode       (mode)
);

// File: tb/lpm_refresh_seq_test.sv
`timescale 1ns/1ps
module lpm_refresh_seq_test;

  localparam int REFI = 40;
  localparam int RFC  = 5;
  localparam int XSR  = 6;
  localparam int MAXO = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 1'b0, dpd_req = 1'b0, overtemp = 1'b0, banks_idle = 1'b1;
  logic clk_stable = 1'b1, defer_ref = 1'b0, reinit_ack = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ref_busy;
  logic [2:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lpm_refresh_seq #(
    .REFI_CYC(REFI), .RFC_CYC(RFC), .XSR_CYC(XSR), .MAX_OWED(MAXO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .dpd_req(dpd_req),
    .overtemp(overtemp), .banks_idle(banks_idle), .clk_stable(clk_stable),
    .defer_ref(defer_ref), .reinit_ack(reinit_ack), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ref_busy(ref_busy), .mode(mode)
  );

  // row: {sr, dpd, overtemp, idle, exp_cke, exp_mode[2:0]}
  localparam logic [7:0] VEC [0:6] = '{
    8'b1001_0_010,  // R7 granted self refresh
    8'b1011_1_000,  // R8 refused on over-temperature
    8'b1000_1_000,  // R7 waits on busy banks
    8'b0101_0_100,  // R10 deep power-down granted
    8'b0100_1_000,  // R10 waits on busy banks
    8'b1101_0_100,  // R10 wins over self refresh
    8'b0001_1_000   // R2 plain active
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pin monitor
  int cyc = 0, last_ref = 0, ref_cnt = 0;
  bit have_ref = 0, prev_cke = 1;
  logic [3:0] entry_code = 4'b0111;
  always @(negedge clk) begin
    if (!rst_n) begin
      have_ref = 0;
      prev_cke = 1;
    end else begin
      cyc++;
      if (cke && {cs_n, ras_n, cas_n, we_n} == 4'b0001) begin
        if (have_ref) check("R5 spacing ok", (cyc - last_ref >= RFC) ? 1 : 0, 1);
        ref_cnt++;
        last_ref = cyc;
        have_ref = 1;
      end else if (have_ref && (cyc - last_ref < RFC)) begin
        if (!cke || {cs_n, ras_n, cas_n, we_n} != 4'b0111) check("R5 quiet during tRFC", 0, 1);
      end
      if (!cke && prev_cke) entry_code = {cs_n, ras_n, cas_n, we_n};
      prev_cke = cke;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sr_req = 0; dpd_req = 0; overtemp = 0; banks_idle = 1;
    clk_stable = 1; defer_ref = 0; reinit_ack = 0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int base;
    int xs;

    // R1 reset state
    wait_cyc(2);
    check("R1 cke in reset", cke, 1);
    check("R1 pins in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check("R1 mode in reset", mode, 0);
    check("R1 busy in reset", ref_busy, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 cke after reset", cke, 1);
    check("R1 mode after reset", mode, 0);

    // table walk: entry gating
    for (int i = 0; i < 7; i++) begin
      do_reset();
      sr_req = VEC[i][7]; dpd_req = VEC[i][6]; overtemp = VEC[i][5]; banks_idle = VEC[i][4];
      wait_cyc(4);
      check($sformatf("R7/R8/R10 row %0d mode", i), mode, int'(VEC[i][2:0]));
      check($sformatf("R12 row %0d cke", i), cke, int'(VEC[i][3]));
    end

    // R2 periodic refresh
    do_reset();
    base = ref_cnt;
    wait_cyc(10 * REFI);
    check("R2 refresh count in range", ((ref_cnt - base) >= 9 && (ref_cnt - base) <= 10) ? 1 : 0, 1);

    // R3 deferral, R6 busy flag
    do_reset();
    defer_ref = 1;
    base = ref_cnt;
    wait_cyc(100);
    check("R3 none issued while deferred", ref_cnt - base, 0);
    check("R6 busy while owed", ref_busy, 1);
    wait_cyc(30);
    check("R3 forced at limit", ref_cnt - base, 1);
    defer_ref = 0;
    wait_cyc(20);
    check("R3 owed issued after release", ref_cnt - base, 3);
    check("R6 busy low when none owed", ref_busy, 0);

    // R4 banks busy blocks refresh
    do_reset();
    banks_idle = 0;
    base = ref_cnt;
    wait_cyc(60);
    check("R4 no refresh while banks busy", ref_cnt - base, 0);
    check("R6 busy while blocked", ref_busy, 1);
    banks_idle = 1;
    wait_cyc(5);
    check("R4 refresh once idle", ref_cnt - base, 1);

    // R7 self refresh waits for owed refresh, R12, R9 exit
    do_reset();
    defer_ref = 1;
    wait_cyc(45);
    sr_req = 1;
    base = ref_cnt;
    wait_cyc(10);
    check("R7 held off by owed refresh", mode, 0);
    defer_ref = 0;
    wait_cyc(15);
    check("R7 entered after refresh", mode, 2);
    check("R7 refresh issued first", ref_cnt - base, 1);
    check("R7 entry pattern", entry_code, 4'b0001);
    base = ref_cnt;
    wait_cyc(50);
    check("R12 cke low in self refresh", cke, 0);
    check("R12 no refresh in self refresh", ref_cnt - base, 0);
    sr_req = 0;
    clk_stable = 0;
    wait_cyc(10);
    check("R9 waits for stable clock mode", mode, 2);
    check("R9 waits for stable clock cke", cke, 0);
    clk_stable = 1;
    xs = 0;
    @(negedge clk);
    while (mode == 3'd3 && xs < 50) begin
      if (!cke || {cs_n, ras_n, cas_n, we_n} != 4'b0111) check("R9 NOP with cke high", 0, 1);
      xs++;
      @(negedge clk);
    end
    check("R9 exit padding length", xs, XSR);
    check("R9 active after exit", mode, 0);

    // R10 / R11 deep power-down
    do_reset();
    dpd_req = 1;
    wait_cyc(4);
    check("R10 entry pattern", entry_code, 4'b0110);
    check("R10 mode deep", mode, 4);
    dpd_req = 0;
    wait_cyc(3);
    check("R11 reinit mode", mode, 5);
    check("R11 cke high", cke, 1);
    wait_cyc(20);
    check("R11 reinit held", mode, 5);
    reinit_ack = 1;
    wait_cyc(1);
    reinit_ack = 0;
    wait_cyc(2);
    check("R11 active after ack", mode, 0);

    finish_run();
  end

endmodule